// File: doc/BRIEF.md
# Master Serial Configuration Loader

This block receives a configuration bit stream from an external serial memory. It makes its own configuration clock by dividing the system clock and sends that clock out to the memory. On every rising edge of that clock it takes one data bit, and it packs the bits into bytes, most significant bit first. Each finished byte comes out with a one-cycle valid strobe.

Loading always starts at a slow boot rate. A three-bit rate field sits at a fixed position within the boot portion of the stream. Once the last boot bit has been taken, the divider switches to the rate that the field selects. The switch waits for the next low phase of the configuration clock, so no pulse is ever cut short.

When the block has taken its own number of bits, it raises `done`. The same signal disables the memory's chip enable. The clock keeps running, and every further bit is passed to a daisy-chain output for the next device. The memory's reset is held while the block is in reset or not selected by its mode inputs.

Top module: `serial_cfg_loader`

## Requirements
- R1: The block runs only when `mode_sel[1:0]` is 2'b00; `mode_sel[2]` has no effect. When it does not run, `cfg_clk` stays low, no bits are taken and `byte_valid` stays low.
- R2: While the first BOOT_BYTES*8 bits are being taken, the period of `cfg_clk` is SYS_HZ/2.5 MHz system cycles, which is 48 at 120 MHz. The high and low phases are equal.
- R3: The rate code is made from stream bits RATE_POS, RATE_POS+1 and RATE_POS+2, counted from bit 0 and read most significant bit first. Codes 0 to 7 select 4, 6, 10, 12, 15, 20, 30 and 60 MHz, and the new period is SYS_HZ divided by the selected rate. The code does not change again until the next load.
- R4: A stream whose rate field is 0 runs at 4 MHz after the boot phase.
- R5: The new period starts with the first low phase after the last boot bit is taken. The rising-edge interval that contains this low phase is the old half period plus the new half period. In every clock cycle, the high phase lasts as long as the low phase that came before it.
- R6: Exactly one bit is taken per rising edge of `cfg_clk`. After every eighth bit, `byte_valid` is high for one cycle, and `byte_data` holds those eight bits with the earliest bit in bit 7.
- R7: `done` goes high in the same cycle as the rising edge that takes bit number OWN_BITS, and then stays high. `mem_ce_n` follows `done`.
- R8: After `done`, each bit on `mem_din` appears on `chain_out` in the same system cycle as the `cfg_clk` rising edge that samples it. Before that, `chain_out` is 0.
- R9: `mem_reset` is high during reset and while the block is not running. It is low while the block runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (SYS_HZ) |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | Mode straps; bit 0 and bit 1 must be 0 for the block to run |
| mem_din | input | 1 | Serial data from the configuration memory |
| cfg_clk | output | 1 | Generated configuration clock to the memory |
| mem_reset | output | 1 | Reset to the memory, high while the block is idle |
| mem_ce_n | output | 1 | Active-low chip enable to the memory, high once loading is done |
| done | output | 1 | Own load complete |
| byte_data | output | 8 | Last assembled byte, earliest bit in bit 7 |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| chain_out | output | 1 | Daisy-chain data for the next device |

## Verification
The bench runs one full load for each of the eight rate codes. It measures every interval between rising edges of `cfg_clk` and compares it with arithmetic derived from the rate table. This separates a wrong boot period, a wrong per-code divider, a switch that comes one edge early or late, and a shortened transition pulse. Each stream is pseudo-random apart from the rate field, so the checks on byte packing and daisy-chain forwarding can reveal a bit-order or off-by-one fault. The odd codes run with `mode_sel[2]` set, and a separate run holds a non-running mode to show that nothing moves.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  localparam int unsigned BOOT_RATE_HZ = 2_500_000;

  // rate code -> configuration clock rate in MHz
  function automatic int unsigned code_mhz(input logic [2:0] code);
    case (code)
      3'd0: return 4;
      3'd1: return 6;
      3'd2: return 10;
      3'd3: return 12;
      3'd4: return 15;
      3'd5: return 20;
      3'd6: return 30;
      default: return 60;
    endcase
  endfunction

  // half period in system cycles for a rate code
  function automatic int unsigned code_half(input int unsigned sys_hz, input logic [2:0] code);
    case (code)
      3'd0: return sys_hz / 8_000_000;
      3'd1: return sys_hz / 12_000_000;
      3'd2: return sys_hz / 20_000_000;
      3'd3: return sys_hz / 24_000_000;
      3'd4: return sys_hz / 30_000_000;
      3'd5: return sys_hz / 40_000_000;
      3'd6: return sys_hz / 60_000_000;
      default: return sys_hz / 120_000_000;
    endcase
  endfunction

  function automatic int unsigned boot_half(input int unsigned sys_hz);
    return sys_hz / (2 * BOOT_RATE_HZ);
  endfunction

endpackage

// File: rtl/cfg_clk_gen.sv
module cfg_clk_gen #(
  parameter int unsigned HALF_W    = 5,
  parameter int unsigned BOOT_HALF = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] next_half,
  output logic              cfg_clk,
  output logic              rise_evt,
  output logic              fall_evt
);
  logic [HALF_W-1:0] hc;
  logic [HALF_W-1:0] cur_half;
  logic              step;

  assign step     = (hc == cur_half - 1'b1);
  assign rise_evt = run && step && !cfg_clk;
  assign fall_evt = run && step && cfg_clk;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      hc       <= '0;
      cfg_clk  <= 1'b0;
      cur_half <= HALF_W'(BOOT_HALF);
    end else if (step) begin
      hc      <= '0;
      cfg_clk <= !cfg_clk;
      if (cfg_clk) cur_half <= next_half;  // change only as a low phase begins
    end else begin
      hc <= hc + 1'b1;
    end
  end

  // phase-length tracking for the pulse-width check
  logic [HALF_W:0] ph_len;
  logic [HALF_W:0] last_lo;
  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      ph_len  <= '0;
      last_lo <= '0;
    end else begin
      ph_len <= (rise_evt || fall_evt) ? '0 : ph_len + 1'b1;
      if (rise_evt) last_lo <= ph_len + 1'b1;
    end
  end

  // R5
  equal_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && last_lo != '0) |-> (ph_len + 1'b1 == last_lo));

endmodule

// File: rtl/cfg_bit_unpack.sv
module cfg_bit_unpack #(
  parameter int unsigned BOOT_BITS = 480,
  parameter int unsigned OWN_BITS  = 2048,
  parameter int unsigned RATE_POS  = 100,
  parameter int unsigned CNT_W     = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       rise_evt,
  input  logic       din,
  output logic [7:0] byte_data,
  output logic       byte_valid,
  output logic [2:0] rate_code,
  output logic       boot_phase,
  output logic       done,
  output logic       chain_out
);
  localparam logic [CNT_W-1:0] LAST_BOOT = CNT_W'(BOOT_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_OWN  = CNT_W'(OWN_BITS - 1);
  localparam logic [CNT_W-1:0] FIELD_LO  = CNT_W'(RATE_POS);
  localparam logic [CNT_W-1:0] FIELD_HI  = CNT_W'(RATE_POS + 2);

  logic [CNT_W-1:0] bit_cnt;
  logic [6:0]       sh;
  logic [2:0]       rate_sh;
  logic [2:0]       rate_nxt;
  logic             in_field;

  assign in_field = (bit_cnt >= FIELD_LO) && (bit_cnt <= FIELD_HI);
  assign rate_nxt = in_field ? {rate_sh[1:0], din} : rate_sh;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      bit_cnt    <= '0;
      sh         <= '0;
      rate_sh    <= '0;
      rate_code  <= '0;
      boot_phase <= 1'b1;
      done       <= 1'b0;
      chain_out  <= 1'b0;
      byte_data  <= '0;
      byte_valid <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (rise_evt) begin
        if (!done) begin
          sh      <= {sh[5:0], din};
          bit_cnt <= bit_cnt + 1'b1;
          rate_sh <= rate_nxt;
          if (bit_cnt[2:0] == 3'd7) begin
            byte_data  <= {sh, din};
            byte_valid <= 1'b1;
          end
          if (bit_cnt == LAST_BOOT) begin
            boot_phase <= 1'b0;
            rate_code  <= rate_nxt;
          end
          if (bit_cnt == LAST_OWN) done <= 1'b1;
        end else begin
          chain_out <= din;
        end
      end
    end
  end

  // R6
  one_bit_per_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !rise_evt) |=> $stable(bit_cnt));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && done) |=> done);

  // R3
  rate_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !boot_phase) |=> $stable(rate_code));

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned SYS_HZ     = 120_000_000,
  parameter int unsigned BOOT_BYTES = 60,
  parameter int unsigned RATE_POS   = 100,
  parameter int unsigned OWN_BITS   = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_sel,
  input  logic       mem_din,
  output logic       cfg_clk,
  output logic       mem_reset,
  output logic       mem_ce_n,
  output logic       done,
  output logic [7:0] byte_data,
  output logic       byte_valid,
  output logic       chain_out
);
  localparam int unsigned BOOT_BITS = BOOT_BYTES * 8;
  localparam int unsigned BOOT_HALF = boot_half(SYS_HZ);
  localparam int unsigned HALF_W    = $clog2(BOOT_HALF + 1);
  localparam int unsigned CNT_W     = $clog2(OWN_BITS + 1);

  logic              run_q;
  logic              rise_evt;
  logic              fall_evt;
  logic [2:0]        rate_code;
  logic              boot_phase;
  logic [HALF_W-1:0] next_half;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= (mode_sel[1:0] == 2'b00);
  end

  assign mem_reset = !run_q;
  assign mem_ce_n  = done;

  always_comb begin
    if (boot_phase) next_half = HALF_W'(BOOT_HALF);
    else            next_half = HALF_W'(code_half(SYS_HZ, rate_code));
  end

  cfg_clk_gen #(
    .HALF_W   (HALF_W),
    .BOOT_HALF(BOOT_HALF)
  ) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .next_half(next_half),
    .cfg_clk  (cfg_clk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  cfg_bit_unpack #(
    .BOOT_BITS(BOOT_BITS),
    .OWN_BITS (OWN_BITS),
    .RATE_POS (RATE_POS),
    .CNT_W    (CNT_W)
  ) u_unpack (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_q),
    .rise_evt  (rise_evt),
    .din       (mem_din),
    .byte_data (byte_data),
    .byte_valid(byte_valid),
    .rate_code (rate_code),
    .boot_phase(boot_phase),
    .done      (done),
    .chain_out (chain_out)
  );

  // R1
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !cfg_clk);

  // R9
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_reset |=> !byte_valid);

endmodule

// File: tb/sim_serial_cfg_loader.sv
module sim_serial_cfg_loader;
  localparam int CLK_PERIOD = 10;
  localparam int BOOT_BYTES = 4;
  localparam int BOOT_BITS  = BOOT_BYTES * 8;
  localparam int RATE_POS   = 5;
  localparam int OWN_BITS   = 48;
  localparam int RISES      = 60;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_sel = 3'b000;
  logic       mem_din;
  logic       cfg_clk, mem_reset, mem_ce_n, done, byte_valid, chain_out;
  logic [7:0] byte_data;

  logic [63:0] sbits;
  logic [5:0]  mem_idx;
  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;

  // expected full periods in system cycles at 120 MHz, per rate code
  int period_tab [8] = '{30, 20, 12, 10, 8, 6, 4, 2};

  always #(CLK_PERIOD/2) clk = !clk;

  serial_cfg_loader #(
    .SYS_HZ(120_000_000), .BOOT_BYTES(BOOT_BYTES),
    .RATE_POS(RATE_POS), .OWN_BITS(OWN_BITS)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .mem_din(mem_din),
    .cfg_clk(cfg_clk), .mem_reset(mem_reset), .mem_ce_n(mem_ce_n),
    .done(done), .byte_data(byte_data), .byte_valid(byte_valid),
    .chain_out(chain_out)
  );

  // serial memory model: next bit after each rising configuration clock
  always @(posedge cfg_clk or negedge rst_n)
    if (!rst_n) mem_idx <= '0;
    else        mem_idx <= mem_idx + 1'b1;
  assign mem_din = sbits[mem_idx];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] m);
    rst_n = 1'b0;
    mode_sel = m;
    repeat (3) @(negedge clk);
    check(mem_reset == 1'b1, "R9 reset", mem_reset, 1);
    check(cfg_clk == 1'b0 && done == 1'b0, "R7 reset", done, 0);
    rst_n = 1'b1;
  endtask

  task automatic load_run(input logic [2:0] code);
    logic [63:0] v;
    int n, last_rise, c, half_new, exp_p;
    logic prev;
    v = 64'h9E37_79B9_7F4A_7C15 ^ (64'(code) * 64'h0123_4567_89AB_CDEF);
    v = v ^ (v << 13);
    v = v ^ (v >> 7);
    sbits = v;
    sbits[RATE_POS]   = code[2];
    sbits[RATE_POS+1] = code[1];
    sbits[RATE_POS+2] = code[0];
    do_reset({code[0], 2'b00});   // R1: mode_sel[2] varied
    half_new = period_tab[code] / 2;
    n = 0; c = 0; last_rise = 0; prev = 1'b0;
    while (n < RISES) begin
      @(negedge clk);
      c++;
      if (n > 0) check(mem_reset == 1'b0, "R9 running", mem_reset, 0);
      if (cfg_clk && !prev) begin
        n++;
        if (n > 1) begin
          if (n - 1 < BOOT_BITS)       exp_p = 48;                 // R2
          else if (n - 1 == BOOT_BITS) exp_p = 24 + half_new;      // R5
          else                         exp_p = 2 * half_new;       // R3 R4
          check(c - last_rise == exp_p, (code == 0) ? "R4 period" : "R3 R5 period",
                c - last_rise, exp_p);
        end
        last_rise = c;
        // R6 byte strobe and contents
        if (n <= OWN_BITS && n % 8 == 0) begin
          int k = n / 8 - 1;
          logic [7:0] eb;
          for (int b = 0; b < 8; b++) eb[7-b] = sbits[8*k+b];
          check(byte_valid == 1'b1 && byte_data == eb, "R6 byte", byte_data, eb);
        end else begin
          check(byte_valid == 1'b0, "R6 no strobe", byte_valid, 0);
        end
        // R7 done timing and chip enable
        check(done == (n >= OWN_BITS), "R7 done", done, n >= OWN_BITS);
        check(mem_ce_n == done, "R7 ce", mem_ce_n, done);
        // R8 daisy chain
        if (n > OWN_BITS) check(chain_out == sbits[n-1], "R8 chain", chain_out, sbits[n-1]);
        else              check(chain_out == 1'b0, "R8 chain idle", chain_out, 0);
      end
      prev = cfg_clk;
    end
  endtask

  task automatic idle_run(input logic [2:0] m);
    do_reset(m);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      check(cfg_clk == 1'b0 && byte_valid == 1'b0, "R1 idle", cfg_clk, 0);
      check(mem_reset == 1'b1, "R9 idle", mem_reset, 1);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190_000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190_000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    sbits = '0;
    idle_run(3'b010);
    for (int code = 0; code < 8; code++) load_run(3'(code));
    idle_run(3'b101);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule